// File: doc/BRIEF.md
# DDC1 EDID Serial Transmitter

This block sends display identification bytes to a host over the one-wire DDC1 path. The host's vertical sync pulse is the bit clock. Firmware loads bytes into an eight-entry queue. On each rising VSYNC edge the block moves its serial data output one bit forward. Each byte goes out as a nine-bit packet: the data bits come first, most significant first, and a separator bit at 1 closes the packet. When no byte is waiting at a packet boundary, the line rests at 1.

The queue is filled in one of two ways. Firmware can write bytes to it directly. When auto-load is enabled, firmware can instead read the memory buffer register, and each such read strobe also pushes the byte it returned. A sticky FIFO interrupt flag warns firmware in two cases: when the queue is running low, against a selectable low-water mark, and when the queue is full and further writes would be lost. An enable bit decides whether the flag reaches the interrupt output. Firmware clears the flag by writing 1.

Top module: `ddc1_edid_tx`

## Requirements
- R1: The queue holds up to eight bytes and sends them in the order they were accepted.
- R2: Each byte is sent as nine bits. Data bits 7 down to 0 go first, then one separator bit of 1. The output steps one bit per rising edge of `vsync_i`, and that edge reaches the output within four system clocks.
- R3: When the queue is empty at a packet boundary, `sda_o` stays 1. Transmission resumes on the first VSYNC rise after a byte arrives, and that rise presents bit 7 of the byte.
- R4: A push made while the queue already holds eight bytes is discarded. The stored bytes and the byte count do not change.
- R5: `irq_flag_o` sets when the number of queued bytes not yet started is below N. N is 2, 3, 4 or 5 for `thresh_sel_i` values 00, 01, 10 and 11.
- R6: `irq_flag_o` also sets while the queue holds eight bytes.
- R7: `irq_flag_o` stays set until a cycle with `irq_clr_i` = 1. If a set condition holds in that same cycle, the flag stays set.
- R8: `irq_o` equals `irq_flag_o` while `irq_en_i` = 1, and is 0 while `irq_en_i` = 0.
- R9: With `autoload_en_i` = 1, a cycle with `mbuf_rd_i` = 1 pushes `mbuf_data_i`. With `autoload_en_i` = 0, the strobe pushes nothing. When `wr_en_i` and an auto-load push fall in the same cycle, only `wr_data_i` is pushed.
- R10: While `rst_n` is low, `sda_o` is 1, `irq_flag_o` and `irq_o` are 0, and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| vsync_i | input | 1 | Vertical sync from the host, asynchronous, used as the bit clock |
| sda_o | output | 1 | Serial data output |
| wr_en_i | input | 1 | Firmware write strobe into the queue |
| wr_data_i | input | 8 | Byte written by firmware |
| mbuf_rd_i | input | 1 | Strobe for a firmware read of the memory buffer register |
| mbuf_data_i | input | 8 | Byte returned by that buffer read |
| autoload_en_i | input | 1 | Lets buffer reads push into the queue |
| thresh_sel_i | input | 2 | Low-water select: 00=2, 01=3, 10=4, 11=5 bytes |
| irq_en_i | input | 1 | Passes the flag to `irq_o` |
| irq_clr_i | input | 1 | Write-1 clear of the flag |
| irq_flag_o | output | 1 | Sticky FIFO interrupt flag |
| irq_o | output | 1 | Interrupt request after masking |

## Verification
The assertions assume that `vsync_i` stays at each level for at least two system clocks. Under that assumption, no two synchronized rising edges fall on consecutive clocks, and each shift step follows from exactly one host edge. They also assume that `thresh_sel_i` changes only between observations, so the low-water comparison in one cycle decides the flag in the next. The stimulus holds VSYNC high and low for four clocks each. It changes every control input on the falling clock edge, well clear of packet boundaries. It starts each threshold case from reset, so the queue count is known before the flag is read.

// File: rtl/ddc1_tx_pkg.sv
package ddc1_tx_pkg;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned Q_DEPTH    = 8;
    localparam int unsigned SEL_W      = 2;
    localparam int unsigned MARK_BASE  = 2;
    localparam int unsigned MARK_W     = 4;

    // low-water mark for a threshold select code
    function automatic logic [MARK_W-1:0] low_mark(input logic [SEL_W-1:0] sel);
        return MARK_W'(MARK_BASE) + MARK_W'(sel);
    endfunction
endpackage

// File: rtl/ddc1_tx_vsync_edge.sv
module ddc1_tx_vsync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_i,
    output logic tick_o
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = vsync_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.sync & ~st_q.prev;

    // a rising edge yields exactly one tick
    assert_single_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/ddc1_tx_fifo.sv
module ddc1_tx_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push_i,
    input  logic [W-1:0]                   din_i,
    input  logic                           pop_i,
    output logic [W-1:0]                   dout_o,
    output logic [$clog2(DEPTH+1)-1:0]     count_o,
    output logic                           empty_o,
    output logic                           full_o
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } q_st_t;

    q_st_t st_d, st_q;
    logic  do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push_i && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop_i  && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = din_i;
            st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + AW'(1);
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + AW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_o  = st_q.mem[st_q.rp];
    assign count_o = st_q.cnt;
    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == CW'(DEPTH));

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));

    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> $stable(count_o));

    assert_pop_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/ddc1_tx_shifter.sv
module ddc1_tx_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         avail_i,
    input  logic [W-1:0] byte_i,
    output logic         pop_o,
    output logic         sda_o
);
    localparam int unsigned CNTW = $clog2(W+1);
    localparam logic [CNTW-1:0] SEP_IDX = CNTW'(W);

    typedef struct packed {
        logic            busy;
        logic [CNTW-1:0] idx;
        logic [W-1:0]    sh;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   boundary;

    always_comb begin
        st_d     = st_q;
        boundary = !st_q.busy || (st_q.idx == SEP_IDX);
        pop_o    = tick_i && boundary && avail_i;
        if (tick_i) begin
            if (boundary) begin
                if (avail_i) begin
                    st_d.busy = 1'b1;
                    st_d.idx  = '0;
                    st_d.sh   = byte_i;
                end else begin
                    st_d.busy = 1'b0;
                end
            end else begin
                st_d.sh  = st_q.sh << 1;
                st_d.idx = st_q.idx + CNTW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sda_o = (!st_q.busy || st_q.idx == SEP_IDX) ? 1'b1 : st_q.sh[W-1];

    assert_separator_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q.busy && st_q.idx == CNTW'(W-1)) |=> sda_o);

    assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && boundary && !avail_i) |=> sda_o);

    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(sda_o));
endmodule

// File: rtl/ddc1_edid_tx.sv
module ddc1_edid_tx
    import ddc1_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    output logic              sda_o,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              mbuf_rd_i,
    input  logic [BYTE_W-1:0] mbuf_data_i,
    input  logic              autoload_en_i,
    input  logic [SEL_W-1:0]  thresh_sel_i,
    input  logic              irq_en_i,
    input  logic              irq_clr_i,
    output logic              irq_flag_o,
    output logic              irq_o
);
    localparam int unsigned CW = $clog2(Q_DEPTH+1);

    typedef struct packed {
        logic flag;
    } irq_st_t;

    irq_st_t           st_d, st_q;
    logic              tick, pop, push, empty, full, low, auto_push;
    logic [BYTE_W-1:0] push_data, head;
    logic [CW-1:0]     fifo_cnt;
    logic [MARK_W-1:0] mark;

    ddc1_tx_vsync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsync_i (vsync_i),
        .tick_o  (tick)
    );

    ddc1_tx_fifo #(.W(BYTE_W), .DEPTH(Q_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   (push_data),
        .pop_i   (pop),
        .dout_o  (head),
        .count_o (fifo_cnt),
        .empty_o (empty),
        .full_o  (full)
    );

    ddc1_tx_shifter #(.W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .avail_i (!empty),
        .byte_i  (head),
        .pop_o   (pop),
        .sda_o   (sda_o)
    );

    always_comb begin
        auto_push = autoload_en_i && mbuf_rd_i;
        push      = wr_en_i || auto_push;
        push_data = wr_en_i ? wr_data_i : mbuf_data_i;
        mark      = low_mark(thresh_sel_i);
        low       = (MARK_W'(fifo_cnt) < mark);
        st_d      = st_q;
        st_d.flag = low || full || (st_q.flag && !irq_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_flag_o = st_q.flag;
    assign irq_o      = st_q.flag & irq_en_i;

    assert_low_water_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (MARK_W'(fifo_cnt) < mark) |=> irq_flag_o);

    assert_full_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> irq_flag_o);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag_o && !irq_clr_i) |=> irq_flag_o);

    assert_autoload_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (autoload_en_i && mbuf_rd_i && !full && !pop) |=> (fifo_cnt == $past(fifo_cnt) + CW'(1)));

    assert_no_autoload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!autoload_en_i && !wr_en_i && !pop) |=> $stable(fifo_cnt));
endmodule

// File: tb/ddc1_edid_tx_tb.sv
module ddc1_edid_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync = 1'b0;
    logic       sda;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       mbuf_rd = 1'b0;
    logic [7:0] mbuf_data = '0;
    logic       autoload = 1'b0;
    logic [1:0] thresh = '0;
    logic       irq_en = 1'b0;
    logic       irq_clr = 1'b0;
    logic       irq_flag, irq;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ddc1_edid_tx u_dut (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .sda_o(sda),
        .wr_en_i(wr_en), .wr_data_i(wr_data),
        .mbuf_rd_i(mbuf_rd), .mbuf_data_i(mbuf_data),
        .autoload_en_i(autoload), .thresh_sel_i(thresh),
        .irq_en_i(irq_en), .irq_clr_i(irq_clr),
        .irq_flag_o(irq_flag), .irq_o(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic vpulse();
        @(negedge clk);
        vsync = 1'b1;
        idle(4);
        vsync = 1'b0;
        idle(4);
    endtask

    task automatic recv(output logic [7:0] b, output logic sep);
        for (int i = 7; i >= 0; i--) begin
            vpulse();
            b[i] = sda;
        end
        vpulse();
        sep = sda;
    endtask

    task automatic expect_byte(input logic [7:0] exp, input string req);
        logic [7:0] b;
        logic       s;
        recv(b, s);
        chk(b, exp, req);
        chk(s, 1'b1, "R2 separator");
    endtask

    task automatic clear_flag();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        idle(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic       s;
        // R10 reset state
        idle(2);
        chk(sda, 1'b1, "R10 sda");
        chk(irq_flag, 1'b0, "R10 flag");
        chk(irq, 1'b0, "R10 irq");
        rst_n = 1'b1;
        idle(3);
        chk(irq_flag, 1'b1, "R5 empty below mark");
        // R8 masking
        chk(irq, 1'b0, "R8 masked");
        irq_en = 1'b1; idle(1);
        chk(irq, 1'b1, "R8 enabled");
        irq_en = 1'b0; idle(1);
        chk(irq, 1'b0, "R8 masked again");

        // R3 idle line with empty queue
        for (int k = 0; k < 3; k++) begin
            vpulse();
            chk(sda, 1'b1, "R3 idle high");
        end

        // R1 R2 order and format
        wr(8'hA5); wr(8'h3C); wr(8'h81);
        expect_byte(8'hA5, "R2 byte0");
        expect_byte(8'h3C, "R1 byte1");
        expect_byte(8'h81, "R1 byte2");
        vpulse();
        chk(sda, 1'b1, "R3 idle after drain");
        wr(8'h7E);
        expect_byte(8'h7E, "R3 resume");

        // R4 ninth byte dropped
        do_reset();
        for (int k = 0; k < 9; k++) wr(8'(8'h10 + k * 8'h11));
        for (int k = 0; k < 8; k++) expect_byte(8'(8'h10 + k * 8'h11), "R4 stored order");
        vpulse();
        chk(sda, 1'b1, "R4 ninth dropped");

        // R5 R6 threshold sweep
        for (int t = 0; t < 4; t++) begin
            for (int c = 0; c <= 8; c++) begin
                do_reset();
                thresh = 2'(t);
                for (int k = 0; k < c; k++) wr(8'(k));
                clear_flag();
                idle(1);
                chk(irq_flag, ((c < t + 2) || (c == 8)) ? 1 : 0,
                    (c == 8) ? "R6 full flag" : "R5 low-water");
            end
        end

        // R7 sticky flag
        do_reset();
        thresh = 2'b00;
        wr(8'h11); wr(8'h22); wr(8'h33);
        idle(3);
        chk(irq_flag, 1'b1, "R7 held from reset");
        clear_flag();
        chk(irq_flag, 1'b0, "R7 cleared");
        idle(5);
        chk(irq_flag, 1'b0, "R7 stays clear");
        expect_byte(8'h11, "R1 sticky seq");
        chk(irq_flag, 1'b0, "R5 two left not below 2");
        expect_byte(8'h22, "R1 sticky seq");
        chk(irq_flag, 1'b1, "R5 one left");
        clear_flag();
        chk(irq_flag, 1'b1, "R7 clear loses to set");

        // R9 auto-load
        do_reset();
        autoload = 1'b0;
        @(negedge clk); mbuf_rd = 1'b1; mbuf_data = 8'h5A;
        @(negedge clk); mbuf_rd = 1'b0;
        vpulse();
        chk(sda, 1'b1, "R9 no push when disabled");
        autoload = 1'b1;
        @(negedge clk); mbuf_rd = 1'b1; mbuf_data = 8'h5A;
        @(negedge clk); mbuf_rd = 1'b0;
        expect_byte(8'h5A, "R9 auto push");
        @(negedge clk);
        mbuf_rd = 1'b1; mbuf_data = 8'hC3; wr_en = 1'b1; wr_data = 8'h3C;
        @(negedge clk);
        mbuf_rd = 1'b0; wr_en = 1'b0;
        expect_byte(8'h3C, "R9 write wins");
        vpulse();
        chk(sda, 1'b1, "R9 buffer byte dropped");
        autoload = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule